// File: doc/BRIEF.md
# RV32I Integer Execute Unit

This block is the arithmetic and logic stage of a small 32-bit integer pipeline. It is purely combinational. Each cycle it takes a decoded operation code and a flag that picks the second operand. That operand is either the second register value or an immediate that decode has already sign-extended. From these it produces the value to be written back to the destination register.

The operation set is the base integer computational group:

- add and subtract
- signed and unsigned set-less-than, giving a 0/1 result
- AND, OR and XOR
- left shift, logical right shift and arithmetic right shift
- load-upper-immediate
- add-upper-immediate-to-PC

The block produces no overflow or carry indication. Subtraction exists only in register form, because a negative immediate on the add path serves the same purpose.

Top module: `rv32i_exec_unit`

## Requirements
- R1: Operand B is `imm_val` when `use_imm` is 1 and `rs2_val` when it is 0. Code 0 (add) returns `rs1_val` + operand B.
- R2: Code 1 (subtract) returns `rs1_val` - `rs2_val` when `use_imm` is 0. When `use_imm` is 1 it adds `imm_val` instead, because no subtract-immediate exists.
- R3: Code 2 returns 1 when `rs1_val` < operand B with both read as two's complement, and 0 otherwise.
- R4: Code 3 returns 1 when `rs1_val` < operand B with both read as unsigned, and 0 otherwise.
- R5: Codes 4, 5 and 6 return the bitwise AND, OR and XOR of `rs1_val` and operand B. In immediate form the full 32-bit sign-extended immediate is used.
- R6: Code 7 shifts `rs1_val` left by operand B[4:0] and fills zeros from below. The upper bits of operand B are ignored.
- R7: Code 8 shifts `rs1_val` right by operand B[4:0] and fills zeros from above.
- R8: Code 9 shifts `rs1_val` right by operand B[4:0] and fills from above with copies of the original bit 31.
- R9: Code 10 returns `imm_val`[31:12] in bits 31:12 and zeros in bits 11:0. `rs1_val`, `rs2_val`, `pc_val` and `use_imm` have no effect.
- R10: Code 11 returns `pc_val` + {`imm_val`[31:12], 12 zero bits}.
- R11: Add and subtract wrap modulo 2^32, and no overflow indication exists.
- R12: The canonical no-op gives 0. This is code 0 with `use_imm` = 1, `rs1_val` = 0 and `imm_val` = 0.
- R13: Codes 12 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Decoded operation code (0..11 defined) |
| use_imm | input | 1 | 1 selects the immediate as operand B |
| rs1_val | input | 32 | First source register value |
| rs2_val | input | 32 | Second source register value |
| imm_val | input | 32 | Sign-extended or upper immediate from decode |
| pc_val | input | 32 | Program counter of the instruction |
| rd_val | output | 32 | Result for the destination register |

## Verification
The bench builds the unit with its default width of 32 and a 4-bit code, which gives a 5-bit shift amount. Random vectors therefore reach every shift distance from 0 to 31 and every defined and undefined code. Directed vectors at this width cover:

- the sign boundary at 0x80000000
- all-ones operands in both compare modes
- shift amounts whose upper bits must be dropped
- wraparound of the PC-relative sum

// File: rtl/rv32i_exec_unit.sv
module rv32i_exec_unit #(
  parameter int XLEN = 32,
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] op_sel,
  input  logic            use_imm,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] imm_val,
  input  logic [XLEN-1:0] pc_val,
  output logic [XLEN-1:0] rd_val
);

  localparam int SHAMT_W = $clog2(XLEN);
  localparam int UP_LO   = 12;

  localparam logic [OP_W-1:0] OP_ADD   = OP_W'(0);
  localparam logic [OP_W-1:0] OP_SUB   = OP_W'(1);
  localparam logic [OP_W-1:0] OP_SLT   = OP_W'(2);
  localparam logic [OP_W-1:0] OP_SLTU  = OP_W'(3);
  localparam logic [OP_W-1:0] OP_AND   = OP_W'(4);
  localparam logic [OP_W-1:0] OP_OR    = OP_W'(5);
  localparam logic [OP_W-1:0] OP_XOR   = OP_W'(6);
  localparam logic [OP_W-1:0] OP_SLL   = OP_W'(7);
  localparam logic [OP_W-1:0] OP_SRL   = OP_W'(8);
  localparam logic [OP_W-1:0] OP_SRA   = OP_W'(9);
  localparam logic [OP_W-1:0] OP_LUI   = OP_W'(10);
  localparam logic [OP_W-1:0] OP_AUIPC = OP_W'(11);

  logic [XLEN-1:0]    opb;
  logic [SHAMT_W-1:0] shamt;
  logic               do_sub;
  logic [XLEN-1:0]    sum;
  logic [XLEN-1:0]    upper;

  assign opb    = use_imm ? imm_val : rs2_val;
  assign shamt  = opb[SHAMT_W-1:0];
  assign do_sub = (op_sel == OP_SUB) && !use_imm;
  assign sum    = rs1_val + (do_sub ? ~opb : opb) + XLEN'(do_sub);
  assign upper  = {imm_val[XLEN-1:UP_LO], {UP_LO{1'b0}}};

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB: rd_val = sum;
      OP_SLT:   rd_val = XLEN'($signed(rs1_val) < $signed(opb));
      OP_SLTU:  rd_val = XLEN'(rs1_val < opb);
      OP_AND:   rd_val = rs1_val & opb;
      OP_OR:    rd_val = rs1_val | opb;
      OP_XOR:   rd_val = rs1_val ^ opb;
      OP_SLL:   rd_val = rs1_val << shamt;
      OP_SRL:   rd_val = rs1_val >> shamt;
      OP_SRA:   rd_val = $unsigned($signed(rs1_val) >>> shamt);
      OP_LUI:   rd_val = upper;
      OP_AUIPC: rd_val = pc_val + upper;
      default:  rd_val = '0;
    endcase
  end

  always_comb begin
    if (op_sel == OP_SLT || op_sel == OP_SLTU)
      // R3 R4
      slt_bool_chk: assert (rd_val[XLEN-1:1] == '0);
    if (op_sel == OP_SUB && !use_imm)
      // R2
      sub_inverse_chk: assert (rd_val + rs2_val == rs1_val);
    if (op_sel == OP_SRL && shamt != '0)
      // R7
      srl_zero_fill_chk: assert (rd_val[XLEN-1] == 1'b0);
    if (op_sel == OP_SRA)
      // R8
      sra_sign_fill_chk: assert (rd_val[XLEN-1] == rs1_val[XLEN-1]);
    if (op_sel == OP_SLL && shamt != '0)
      // R6
      sll_zero_fill_chk: assert (rd_val[0] == 1'b0);
    if (op_sel == OP_LUI)
      // R9
      lui_low_zero_chk: assert (rd_val[UP_LO-1:0] == '0);
    if (op_sel > OP_AUIPC)
      // R13
      undef_zero_chk: assert (rd_val == '0);
  end

endmodule

// File: tb/tb_rv32i_exec_unit.sv
module tb_rv32i_exec_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic [3:0]  op_sel;
  logic        use_imm;
  logic [31:0] rs1_val, rs2_val, imm_val, pc_val, rd_val;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rv32i_exec_unit dut (
    .op_sel(op_sel), .use_imm(use_imm), .rs1_val(rs1_val), .rs2_val(rs2_val),
    .imm_val(imm_val), .pc_val(pc_val), .rd_val(rd_val)
  );

  function automatic logic [31:0] model(input logic [3:0] op, input logic ui,
      input logic [31:0] a, input logic [31:0] r2, input logic [31:0] im, input logic [31:0] p);
    logic [31:0] b, up;
    int sh;
    b  = ui ? im : r2;
    sh = int'(b[4:0]);
    up = im & 32'hFFFF_F000;
    case (op)
      4'd0: return a + b;
      4'd1: return ui ? a + b : a + ~b + 32'd1;
      4'd2: return (a[31] != b[31]) ? {31'd0, a[31]} : {31'd0, a < b};
      4'd3: return {31'd0, a < b};
      4'd4: return a & b;
      4'd5: return a | b;
      4'd6: return a ^ b;
      4'd7: return a << sh;
      4'd8: return a >> sh;
      4'd9: return (a >> sh) | (a[31] ? ~(32'hFFFF_FFFF >> sh) : 32'd0);
      4'd10: return up;
      4'd11: return p + up;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";  4'd1: return "R2";  4'd2: return "R3";  4'd3: return "R4";
      4'd4, 4'd5, 4'd6: return "R5";
      4'd7: return "R6";  4'd8: return "R7";  4'd9: return "R8";
      4'd10: return "R9"; 4'd11: return "R10";
      default: return "R13";
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic ui, input logic [31:0] a,
      input logic [31:0] r2, input logic [31:0] im, input logic [31:0] p,
      input logic [31:0] exp, input string tag);
    @(posedge clk);
    op_sel = op; use_imm = ui; rs1_val = a; rs2_val = r2; imm_val = im; pc_val = p;
    @(negedge clk);
    n_chk++;
    if (rd_val !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d imm=%0b a=%h b=%h i=%h pc=%h: got %h expected %h",
               tag, op, ui, a, r2, im, p, rd_val, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r, a, r2, im, p;
    logic [3:0] op;
    logic ui;
    void'($urandom(32'h5EED_0042));
    op_sel = 0; use_imm = 0; rs1_val = 0; rs2_val = 0; imm_val = 0; pc_val = 0;

    apply(4'd0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, "R1");
    apply(4'd0, 1'b1, 32'h0, 32'h1234_5678, 32'h0, 32'h40, 32'h0, "R12");
    apply(4'd0, 1'b0, 32'h0000_0007, 32'h0000_0009, 32'hFFFF_FFFF, 0, 32'h10, "R1");
    apply(4'd0, 1'b1, 32'h0000_0007, 32'h0000_0009, 32'hFFFF_FFFF, 0, 32'h6, "R1");
    apply(4'd0, 1'b0, 32'hFFFF_FFFF, 32'h1, 0, 0, 32'h0, "R11");
    apply(4'd0, 1'b0, 32'h7FFF_FFFF, 32'h1, 0, 0, 32'h8000_0000, "R11");
    apply(4'd1, 1'b0, 32'h0, 32'h1, 0, 0, 32'hFFFF_FFFF, "R11");
    apply(4'd1, 1'b0, 32'h8000_0000, 32'h1, 0, 0, 32'h7FFF_FFFF, "R2");
    apply(4'd1, 1'b1, 32'd10, 32'd3, 32'd5, 0, 32'd15, "R2");
    apply(4'd2, 1'b0, 32'hFFFF_FFFF, 32'h1, 0, 0, 32'h1, "R3");
    apply(4'd2, 1'b1, 32'h0, 32'h0, 32'hFFFF_FFFF, 0, 32'h0, "R3");
    apply(4'd2, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 32'h1, "R3");
    apply(4'd2, 1'b0, 32'h5, 32'h5, 0, 0, 32'h0, "R3");
    apply(4'd3, 1'b0, 32'hFFFF_FFFF, 32'h1, 0, 0, 32'h0, "R4");
    apply(4'd3, 1'b1, 32'h5, 32'h0, 32'hFFFF_FFFF, 0, 32'h1, "R4");
    apply(4'd4, 1'b1, 32'hFFFF_FFFF, 0, 32'hFFFF_F800, 0, 32'hFFFF_F800, "R5");
    apply(4'd5, 1'b1, 32'h0000_0001, 0, 32'hFFFF_FF80, 0, 32'hFFFF_FF81, "R5");
    apply(4'd6, 1'b0, 32'hAAAA_5555, 32'hFFFF_0000, 0, 0, 32'h5555_5555, "R5");
    apply(4'd7, 1'b0, 32'h1, 32'd33, 0, 0, 32'h2, "R6");
    apply(4'd7, 1'b1, 32'h1, 0, 32'd31, 0, 32'h8000_0000, "R6");
    apply(4'd8, 1'b0, 32'h8000_0000, 32'd31, 0, 0, 32'h1, "R7");
    apply(4'd8, 1'b0, 32'hF000_0000, 32'd4, 0, 0, 32'h0F00_0000, "R7");
    apply(4'd9, 1'b0, 32'h8000_0000, 32'd31, 0, 0, 32'hFFFF_FFFF, "R8");
    apply(4'd9, 1'b1, 32'hF000_0000, 0, 32'd4, 0, 32'hFF00_0000, "R8");
    apply(4'd9, 1'b0, 32'h8765_4321, 32'h20, 0, 0, 32'h8765_4321, "R8");
    apply(4'd10, 1'b0, 32'hDEAD_BEEF, 32'h1, 32'h1234_5FFF, 32'h100, 32'h1234_5000, "R9");
    apply(4'd10, 1'b1, 32'h1, 32'h2, 32'h1234_5FFF, 32'h0, 32'h1234_5000, "R9");
    apply(4'd11, 1'b0, 0, 0, 32'hFFFF_F000, 32'h1000, 32'h0, "R10");
    apply(4'd11, 1'b1, 32'h77, 0, 32'h0000_2ABC, 32'h0000_0400, 32'h0000_2400, "R10");
    for (int k = 12; k < 16; k++)
      apply(4'(k), 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R13");

    for (int n = 0; n < 3000; n++) begin
      op = 4'($urandom_range(0, 15));
      ui = 1'($urandom);
      a  = $urandom;
      r2 = $urandom;
      r  = $urandom;
      p  = $urandom;
      if (n % 8 == 0) a = (n % 16 == 0) ? 32'h8000_0000 : 32'hFFFF_FFFF;
      im = (op == 4'd10 || op == 4'd11) ? r : {{20{r[11]}}, r[11:0]};
      apply(op, ui, a, r2, im, p, model(op, ui, a, r2, im, p), tag_of(op));
    end
    finish_run();
  end
endmodule